// File: doc/BRIEF.md
# Oversampled Serial Receiver with Byte Queue and Sticky Error Flag

The block turns an asynchronous serial line into bytes. The line is sampled once on each pulse of an oversampling enable that runs at sixteen times the bit rate. Each frame holds a start bit, eight data bits sent least significant bit first, an optional parity bit and one or two stop bits. Every completed character is checked for its stop bit and, when parity is enabled, for its parity. Accepted bytes go into a sixteen-entry first-in first-out queue. Software drains the queue through a pop strobe.

A single sticky error flag records three faults: a bad stop bit, a parity mismatch, and a character that arrives while the queue is full. A character that has a bad stop bit or bad parity is still queued. A control input decides whether reception pauses after such a character. A character that arrives into a full queue is thrown away, and reception stays stopped until the flag is cleared. Software clears the flag by first reading it as 1 and then writing 0. A standby input or a reset also clears it.

Top module: `async_rx_core`

## Requirements
- R1: After reset the queue count is 0, the error flag is 0 and the read data output is 0x00.
- R2: A frame carries 8 data bits, least significant bit first, and ends up as one queue entry. A pop strobe returns the oldest entry on `rd_data` one clock later and lowers `fifo_cnt` by one. Entries leave in the order they arrived.
- R3: A falling edge is taken as a start bit only if the line is still low at the middle sample of the start bit, which is the 8th oversampling pulse. A shorter low pulse produces no byte.
- R4: When `par_en` is 1, a parity bit follows the eighth data bit. The total number of 1s in the data plus the parity bit must be even when `par_odd` is 0 and odd when `par_odd` is 1. A mismatch sets the error flag, and the byte is still queued. When `par_en` is 0, no parity bit is expected.
- R5: A first stop bit sampled as 0 sets the error flag, and the byte is still queued.
- R6: When `two_stop` is 1, only the first stop bit is checked. A second stop bit of 0 causes no error.
- R7: A frame that completes while the queue holds 16 bytes sets the error flag. That byte is dropped, and no further frame is taken until the flag has been cleared.
- R8: After a stop-bit or parity error, reception pauses until the flag is cleared when `err_int_en` is 1, and goes on when `err_int_en` is 0.
- R9: A `flag_wr` with `flag_wdata` of 0 clears the flag only if a `flag_rd` saw the flag at 1 since the last write. Any write uses up that earlier read. Writing 1 never changes the flag.
- R10: Pulsing `standby` clears the error flag and ends any pause in reception.
- R11: While `rx_en` is 0, no frame is received and the error flag keeps its value.
- R12: A pop from an empty queue leaves `rd_data` at its previous value and `fifo_cnt` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Clears the error flag and any pause in reception |
| os_tick | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | A parity bit is present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Frame has two stop bits |
| err_int_en | input | 1 | Pause reception after a stop-bit or parity error |
| rd_pop | input | 1 | Pop the oldest queue entry |
| rd_data | output | 8 | Last popped byte |
| fifo_cnt | output | 5 | Number of bytes in the queue |
| flag_rd | input | 1 | Read strobe for the error flag, arms a later clear |
| flag_wr | input | 1 | Write strobe for the error flag |
| flag_wdata | input | 1 | Write value; 0 clears the flag if it was armed |
| err_flag | output | 1 | Sticky receive error flag |

## Verification
The hardest state to reach is a locked overrun. It needs sixteen clean frames queued and then a seventeenth. The bench must then show that a frame sent while locked is lost even after a pop has made room, and that the very next frame after a proper clear is accepted. The stimulus fills the queue with a run of distinct bytes and pops one entry while still locked. It performs the read-then-write-zero clear and then drains the whole queue against a behavioural queue model, which shows both the drop and the order of the entries. Clearing through a bare write, or through a read followed by a write of 1, is tried first while the flag is set, so that an arm that was used up is shown to block the clear.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int RX_DATA_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } rx_fmt_t;

    typedef struct packed {
        logic [RX_DATA_BITS-1:0] data;
        logic                    frame_err;
        logic                    par_err;
    } rx_frame_t;

    function automatic logic parity_mismatch(
        input logic [RX_DATA_BITS-1:0] d,
        input logic                    pbit,
        input logic                    odd
    );
        return (^{d, pbit}) != odd;
    endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import async_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      tick,
    input  logic      rxd,
    input  rx_fmt_t   fmt,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(RX_DATA_BITS);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB = BW'(RX_DATA_BITS - 1);

    rx_state_e               st;
    logic [CW-1:0]           cnt;
    logic [BW-1:0]           bidx;
    logic [RX_DATA_BITS-1:0] sh;
    logic                    pe_q;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sh    <= '0;
            pe_q  <= 1'b0;
            frame <= '0;
        end else if (!run) begin
            st  <= RX_IDLE;
            cnt <= '0;
        end else if (tick) begin
            unique case (st)
                RX_IDLE: begin
                    if (!rxd) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == MID) begin
                        cnt  <= '0;
                        bidx <= '0;
                        pe_q <= 1'b0;
                        st   <= rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        sh   <= {rxd, sh[RX_DATA_BITS-1:1]};
                        bidx <= bidx + 1'b1;
                        if (bidx == TOPB)
                            st <= fmt.par_en ? RX_PAR : RX_STOP1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        pe_q <= parity_mismatch(sh, rxd, fmt.par_odd);
                        st   <= RX_STOP1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP1: begin
                    if (cnt == LAST) begin
                        cnt             <= '0;
                        frame.data      <= sh;
                        frame.frame_err <= !rxd;
                        frame.par_err   <= pe_q;
                        if (fmt.two_stop) begin
                            st <= RX_STOP2;
                        end else begin
                            st   <= RX_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        st   <= RX_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R2: one completion pulse per frame
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: data phase entered only after a low mid-bit start sample
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA && $past(st) == RX_START) |-> !$past(rxd));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rdata  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop) begin
                rdata  <= mem[rd_ptr];
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);

    // R12: empty pop leaves data and count alone
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> (count == '0 && $stable(rdata)));

    // R2: a lone pop lowers the count by one
    a_r2_pop_dec: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic frame_done,
    input  logic frame_err,
    input  logic par_err,
    input  logic fifo_full,
    input  logic halt_on_err,
    input  logic flag_rd,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic err_flag,
    output logic locked
);
    logic armed;
    logic ovr_ev, bad_ev, set_ev, clr_ev, lock_ev;

    assign ovr_ev  = frame_done && fifo_full;
    assign bad_ev  = frame_done && !fifo_full && (frame_err || par_err);
    assign set_ev  = ovr_ev || bad_ev;
    assign clr_ev  = flag_wr && !flag_wdata && armed;
    assign lock_ev = ovr_ev || (bad_ev && halt_on_err);

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            err_flag <= 1'b0;
            locked   <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (set_ev)
                err_flag <= 1'b1;
            else if (clr_ev)
                err_flag <= 1'b0;

            if (lock_ev)
                locked <= 1'b1;
            else if (clr_ev)
                locked <= 1'b0;

            if (flag_wr)
                armed <= 1'b0;
            else if (flag_rd && err_flag)
                armed <= 1'b1;
        end
    end

    // R9: flag falls only through an armed zero write, standby or reset
    a_r9_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $fell(err_flag) |-> ($past(rst) || $past(standby) ||
                             ($past(armed) && $past(flag_wr) && !$past(flag_wdata))));

    // R7: full-queue completion flags and locks
    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (frame_done && fifo_full && !standby) |=> (err_flag && locked));

    // R11: without a frame, a write or standby the flag holds
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !flag_wr && !standby) |=> $stable(err_flag));

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OSR        = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              standby,
    input  logic                              os_tick,
    input  logic                              rxd,
    input  logic                              rx_en,
    input  logic                              par_en,
    input  logic                              par_odd,
    input  logic                              two_stop,
    input  logic                              err_int_en,
    input  logic                              rd_pop,
    output logic [RX_DATA_BITS-1:0]           rd_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_cnt,
    input  logic                              flag_rd,
    input  logic                              flag_wr,
    input  logic                              flag_wdata,
    output logic                              err_flag
);
    rx_fmt_t   fmt;
    rx_frame_t frame;
    logic      frame_done;
    logic      locked;
    logic      run;
    logic      fifo_full;
    logic      push;

    assign fmt.par_en   = par_en;
    assign fmt.par_odd  = par_odd;
    assign fmt.two_stop = two_stop;

    assign run  = rx_en && !locked;
    assign push = frame_done && !fifo_full;

    rx_sampler #(.OSR(OSR)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .tick  (os_tick),
        .rxd   (rxd),
        .fmt   (fmt),
        .done  (frame_done),
        .frame (frame)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH), .W(RX_DATA_BITS)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (frame.data),
        .pop   (rd_pop),
        .rdata (rd_data),
        .count (fifo_cnt),
        .full  (fifo_full)
    );

    rx_err_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .standby     (standby),
        .frame_done  (frame_done),
        .frame_err   (frame.frame_err),
        .par_err     (frame.par_err),
        .fifo_full   (fifo_full),
        .halt_on_err (err_int_en),
        .flag_rd     (flag_rd),
        .flag_wr     (flag_wr),
        .flag_wdata  (flag_wdata),
        .err_flag    (err_flag),
        .locked      (locked)
    );

    // R7, R8: no frame completes while reception is locked
    a_r8_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        locked |-> !frame_done);

endmodule

// File: tb/async_rx_core_tb.sv
module async_rx_core_tb;

    localparam int BITC = 64;

    logic       clk = 1'b0;
    logic       rst, standby, os_tick, rxd, rx_en, par_en, par_odd, two_stop, err_int_en;
    logic       rd_pop, flag_rd, flag_wr, flag_wdata;
    logic [7:0] rd_data;
    logic [4:0] fifo_cnt;
    logic       err_flag;

    always #4 clk = ~clk;

    async_rx_core u_dut (
        .clk(clk), .rst(rst), .standby(standby), .os_tick(os_tick), .rxd(rxd),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .err_int_en(err_int_en), .rd_pop(rd_pop), .rd_data(rd_data), .fifo_cnt(fifo_cnt),
        .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .err_flag(err_flag)
    );

    int tests = 0;
    int fails = 0;
    bit done_run = 0;

    logic [7:0] mq[$];
    logic [7:0] m_last = 8'h00;
    bit m_flag = 0, m_lock = 0, m_arm = 0;
    bit chk_en = 0;

    int tdiv = 0;
    always @(negedge clk) begin
        if (rst) begin
            tdiv    = 0;
            os_tick = 1'b0;
        end else begin
            os_tick = (tdiv == 3);
            tdiv    = (tdiv == 3) ? 0 : tdiv + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model compared on every clock while the line is quiet
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            check("R2", int'(fifo_cnt), mq.size(), "count vs model");
            check("R9", int'(err_flag), int'(m_flag), "flag vs model");
        end
    end

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit stop2_low);
        chk_en = 0;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (par_en) line_bit((^d) ^ par_odd ^ bad_par);
        line_bit(!bad_stop);
        if (two_stop) line_bit(!stop2_low);
        line_bit(1'b1);
        line_bit(1'b1);
        if (rx_en && !m_lock) begin
            if (mq.size() == 16) begin
                m_flag = 1;
                m_lock = 1;
            end else begin
                mq.push_back(d);
                if ((bad_par && par_en) || bad_stop) begin
                    m_flag = 1;
                    if (err_int_en) m_lock = 1;
                end
            end
        end
        chk_en = 1;
    endtask

    task automatic pop_check(input string req);
        logic [7:0] exp;
        chk_en = 0;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (mq.size() > 0) begin
            exp    = mq.pop_front();
            m_last = exp;
        end else begin
            exp = m_last;
        end
        check(req, int'(rd_data), int'(exp), "popped byte");
        chk_en = 1;
    endtask

    task automatic flag_read(input string req);
        chk_en = 0;
        check(req, int'(err_flag), int'(m_flag), "flag read");
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        m_arm   = m_flag;
        chk_en  = 1;
    endtask

    task automatic flag_write(input logic v);
        chk_en     = 0;
        flag_wr    = 1'b1;
        flag_wdata = v;
        @(negedge clk);
        flag_wr = 1'b0;
        if (!v && m_arm) begin
            m_flag = 0;
            m_lock = 0;
        end
        m_arm  = 0;
        chk_en = 1;
    endtask

    task automatic clear_flag();
        flag_read("R9");
        flag_write(1'b0);
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) pop_check(req);
    endtask

    initial begin
        rst = 1'b1; standby = 1'b0; rxd = 1'b1; rx_en = 1'b1; par_en = 1'b0;
        par_odd = 1'b0; two_stop = 1'b0; err_int_en = 1'b0; rd_pop = 1'b0;
        flag_rd = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(fifo_cnt), 0, "count after reset");
        check("R1", int'(err_flag), 0, "flag after reset");
        check("R1", int'(rd_data), 0, "data after reset");
        chk_en = 1;

        // R2: plain frames, order and pop timing
        send_frame(8'hA5, 0, 0, 0);
        send_frame(8'h3C, 0, 0, 0);
        send_frame(8'h01, 0, 0, 0);
        check("R2", int'(fifo_cnt), 3, "three queued");
        drain("R2");
        // R12: empty pop keeps last byte
        pop_check("R12");
        check("R12", int'(fifo_cnt), 0, "count after empty pop");

        // R3: short low pulse is not a start bit
        chk_en = 0;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        check("R3", int'(fifo_cnt), 0, "glitch rejected");
        chk_en = 1;
        send_frame(8'h96, 0, 0, 0);
        pop_check("R3");

        // R4: even and odd parity
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h5A, 0, 0, 0);
        check("R4", int'(err_flag), 0, "even parity good");
        par_odd = 1'b1;
        send_frame(8'h81, 0, 0, 0);
        check("R4", int'(err_flag), 0, "odd parity good");
        send_frame(8'h77, 1, 0, 0);
        check("R4", int'(err_flag), 1, "odd parity bad");
        check("R4", int'(fifo_cnt), 3, "bad parity byte kept");
        drain("R4");

        // R9: clear handshake
        flag_write(1'b0);
        check("R9", int'(err_flag), 1, "write 0 without read");
        flag_read("R9");
        flag_write(1'b1);
        check("R9", int'(err_flag), 1, "write 1 after read");
        flag_write(1'b0);
        check("R9", int'(err_flag), 1, "arm used by write 1");
        clear_flag();
        check("R9", int'(err_flag), 0, "read then write 0");

        // R5: framing error keeps byte
        par_en = 1'b0;
        send_frame(8'hC3, 0, 1, 0);
        check("R5", int'(err_flag), 1, "stop bit low");
        pop_check("R5");
        clear_flag();

        // R6: second stop bit ignored
        two_stop = 1'b1;
        send_frame(8'h6E, 0, 0, 1);
        check("R6", int'(err_flag), 0, "second stop low ignored");
        pop_check("R6");
        send_frame(8'h2B, 0, 1, 0);
        check("R6", int'(err_flag), 1, "first stop low checked");
        pop_check("R6");
        two_stop = 1'b0;

        // R10: standby clears flag
        chk_en  = 0;
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        m_flag = 0; m_lock = 0; m_arm = 0;
        check("R10", int'(err_flag), 0, "standby clear");
        chk_en = 1;

        // R8: halt versus continue after parity error
        par_en = 1'b1; par_odd = 1'b0; err_int_en = 1'b1;
        send_frame(8'h44, 1, 0, 0);
        check("R8", int'(fifo_cnt), 1, "bad byte kept, halting");
        send_frame(8'h55, 0, 0, 0);
        check("R8", int'(fifo_cnt), 1, "halted frame lost");
        clear_flag();
        send_frame(8'h66, 0, 0, 0);
        check("R8", int'(fifo_cnt), 2, "resumed after clear");
        err_int_en = 1'b0;
        send_frame(8'h12, 1, 0, 0);
        send_frame(8'h34, 0, 0, 0);
        check("R8", int'(fifo_cnt), 4, "continues with flag set");
        check("R8", int'(err_flag), 1, "flag still set");
        drain("R8");

        // R11: disabled receiver, flag retained
        rx_en = 1'b0;
        send_frame(8'h99, 0, 0, 0);
        check("R11", int'(fifo_cnt), 0, "disabled: no byte");
        check("R11", int'(err_flag), 1, "disabled: flag kept");
        rx_en = 1'b1;
        clear_flag();
        par_en = 1'b0;

        // R7: overrun drops byte and locks
        for (int i = 0; i < 16; i++) send_frame(8'(i * 17 + 3), 0, 0, 0);
        check("R7", int'(fifo_cnt), 16, "queue full");
        check("R7", int'(err_flag), 0, "no error when just full");
        send_frame(8'hF0, 0, 0, 0);
        check("R7", int'(err_flag), 1, "overrun flagged");
        check("R7", int'(fifo_cnt), 16, "overrun byte dropped");
        pop_check("R7");
        send_frame(8'hF1, 0, 0, 0);
        check("R7", int'(fifo_cnt), 15, "locked after overrun");
        clear_flag();
        send_frame(8'hEE, 0, 0, 0);
        check("R7", int'(fifo_cnt), 16, "accepted after clear");
        drain("R7");

        done_run = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule